// File: doc/BRIEF.md
# Hidden and Forced Refresh Arbiter

This block decides when a dynamic memory refresh cycle is started. Time is divided into refresh-clock periods, and each period needs one refresh. The system normally runs in the auto-access mode, and the arbiter uses idle time there to slip in a hidden refresh between accesses. It starts at most one such refresh in each period. If a whole period goes by without one, the arbiter pulls its active-low request line low. It keeps that request until the system acknowledges it by switching into the forced-refresh mode. The arbiter then runs one refresh and releases the request.

Each refresh start is a single-cycle pulse. That pulse drives the refresh address counter and the cycle sequencer, and neither of those is part of this block. A refresh lasts `RF_CYC` clock cycles. The column strobe is held off during a refresh and for as long as the forced-refresh mode is selected. The refresh clock is asynchronous to the system clock, so it is brought in through a synchronizer of `SYNC_STAGES` flops. Only its rising edges mark period boundaries.

If the refresh clock is held high, no period boundaries occur. The forced-refresh mode then works as a direct refresh command: one refresh is run each time that mode is entered.

Top module: `refresh_arbiter`

## Requirements
- R1: During and directly after reset, `rfreq_n` is 1 and `rfsh_go` is 0, and `cas_inh` is 0 unless the mode is forced-refresh.
- R2: When all of the following hold, exactly one refresh starts and `rfsh_go` is high for exactly one cycle:
  - the mode is auto-access (`mode` = 3'b101);
  - `acc_busy` is 0;
  - no refresh is in progress;
  - no hidden refresh has yet run in the current period;
  - no request is pending.
- R3: At most one hidden refresh starts per refresh-clock period, however long the access side stays idle.
- R4: If a hidden refresh ran in the period, a rising edge of `rfck` leaves `rfreq_n` high. It also re-opens the slot, so the next period gets its own hidden refresh.
- R5: A rising edge of `rfck` that ends a period without a hidden refresh drives `rfreq_n` low. `rfreq_n` stays low until the request is served.
- R6: While a request is pending, no hidden refresh starts, even in an idle auto-access mode.
- R7: In the forced-refresh mode (`mode` = 3'b001), one refresh starts as soon as no refresh is in progress.
- R8: After the forced refresh that serves a pending request, `rfreq_n` returns high. This happens in the cycle after the last of its `RF_CYC` refresh cycles, not earlier.
- R9: While the forced-refresh mode stays selected, no second forced refresh starts until the next rising edge of `rfck`.
- R10: With `rfck` held constant, each entry into the forced-refresh mode starts exactly one refresh.
- R11: `cas_inh` is 1 in the `RF_CYC` cycles of every refresh, counted from the cycle in which `rfsh_go` is high, and whenever the forced-refresh mode is selected. Otherwise it is 0.
- R12: Mode values other than 3'b101 and 3'b001 start no refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfck | input | 1 | Refresh clock; each rising edge ends a period |
| mode | input | 3 | Mode select: 3'b101 auto-access, 3'b001 forced refresh |
| acc_busy | input | 1 | High while a memory access is in progress |
| rfreq_n | output | 1 | Active-low forced-refresh request |
| rfsh_go | output | 1 | One-cycle pulse starting a refresh cycle |
| cas_inh | output | 1 | Column strobe inhibit |

## Verification
The bench builds the arbiter with `RF_CYC` = 3 and `SYNC_STAGES` = 2. With a short refresh cycle, the request release can be checked within a few cycles of the forced refresh. That makes it easy to confirm that `rfreq_n` is still low in the last refresh cycle and high in the next one. Two synchronizer stages keep the delay from an `rfck` edge to the request short. Long idle windows, which are far longer than a refresh, then show that no second hidden or forced refresh starts within the same period.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  localparam logic [2:0] MODE_AUTO   = 3'b101;
  localparam logic [2:0] MODE_FORCED = 3'b001;
endpackage

// File: rtl/rfa_edge_sync.sv
module rfa_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rfa_cycle_timer.sv
module rfa_cycle_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)            cnt_d = LOAD;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/rfa_period_track.sv
module rfa_period_track (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic hid_fire,
  input  logic served,
  output logic hid_seen,
  output logic req
);
  logic seen_d, req_d;

  always_comb begin
    seen_d = hid_seen;
    req_d  = req;
    if (hid_fire) seen_d = 1'b1;
    if (served)   req_d  = 1'b0;
    if (rise) begin
      seen_d = 1'b0;
      if (!(hid_seen || hid_fire)) req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hid_seen <= 1'b0;
      req      <= 1'b0;
    end else begin
      hid_seen <= seen_d;
      req      <= req_d;
    end
  end
endmodule

// File: rtl/refresh_arbiter.sv
module refresh_arbiter #(
  parameter int RF_CYC      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rfck,
  input  logic [2:0] mode,
  input  logic       acc_busy,
  output logic       rfreq_n,
  output logic       rfsh_go,
  output logic       cas_inh
);
  import rfa_pkg::*;

  logic rise, busy, last, hid_seen, req;
  logic in_auto, in_forced, hid_fire, frc_fire, fire;
  logic fdone_q, fdone_d, kind_q, kind_d, go_q;

  rfa_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rfck), .rise(rise)
  );

  rfa_cycle_timer #(.CYCLES(RF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(fire), .busy(busy), .last(last)
  );

  rfa_period_track u_track (
    .clk(clk), .rst_n(rst_n), .rise(rise), .hid_fire(hid_fire),
    .served(last & kind_q), .hid_seen(hid_seen), .req(req)
  );

  assign in_auto   = (mode == MODE_AUTO);
  assign in_forced = (mode == MODE_FORCED);
  assign hid_fire  = in_auto & ~acc_busy & ~busy & ~hid_seen & ~req;
  assign frc_fire  = in_forced & ~busy & ~fdone_q;
  assign fire      = hid_fire | frc_fire;

  always_comb begin
    fdone_d = fdone_q;
    if (!in_forced || rise) fdone_d = 1'b0;
    else if (frc_fire)      fdone_d = 1'b1;
    kind_d = fire ? (frc_fire & req) : kind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fdone_q <= 1'b0;
      kind_q  <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      fdone_q <= fdone_d;
      kind_q  <= kind_d;
      go_q    <= fire;
    end
  end

  assign rfreq_n = ~req;
  assign rfsh_go = go_q;
  assign cas_inh = in_forced | busy;
endmodule

// File: rtl/refresh_arbiter_chk.sv
module refresh_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       rfreq_n,
  input logic       rfsh_go,
  input logic       cas_inh
);
  import rfa_pkg::*;

  // R2
  go_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_go |=> !rfsh_go);

  // R11
  go_inhibits_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_go |-> cas_inh);

  // R6
  no_hidden_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_go |-> ($past(mode) == MODE_FORCED || $past(rfreq_n)));

  // R8
  release_after_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfreq_n) |-> $past(cas_inh));

  // R12
  go_only_in_refresh_modes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_go |-> ($past(mode) == MODE_AUTO || $past(mode) == MODE_FORCED));
endmodule

bind refresh_arbiter refresh_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rfreq_n(rfreq_n),
  .rfsh_go(rfsh_go), .cas_inh(cas_inh)
);

// File: tb/refresh_arbiter_tb.sv
module refresh_arbiter_tb;
  localparam int RF_CYC = 3;
  localparam logic [2:0] M_AUTO = 3'b101;
  localparam logic [2:0] M_FRC  = 3'b001;
  localparam logic [2:0] M_EXT  = 3'b100;

  logic clk = 1'b0;
  logic rst_n, rfck, acc_busy;
  logic [2:0] mode;
  logic rfreq_n, rfsh_go, cas_inh;
  int checks = 0;
  int fails = 0;
  logic [2:0] expq[$];

  always #2.5 clk = ~clk;

  refresh_arbiter #(.RF_CYC(RF_CYC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .rfck(rfck), .mode(mode), .acc_busy(acc_busy),
    .rfreq_n(rfreq_n), .rfsh_go(rfsh_go), .cas_inh(cas_inh)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic expect_go(input logic [2:0] m);
    expq.push_back(m);
  endtask

  task automatic drained(input string req);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL %s actual=%0d pending refreshes expected=0", req, expq.size());
      expq.delete();
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every refresh pulse must match a queued expectation
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rfsh_go) begin
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R3/R9/R12 unexpected refresh actual=mode %b expected=none", mode);
        end else begin
          logic [2:0] e;
          e = expq.pop_front();
          if (e !== mode) begin
            fails++;
            $display("FAIL R2/R7 refresh mode actual=%b expected=%b", mode, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rfck = 1'b0; acc_busy = 1'b1; mode = M_EXT;
    cyc(3);
    chk("R1 rfreq_n in reset", rfreq_n, 1'b1);
    chk("R1 rfsh_go in reset", rfsh_go, 1'b0);
    chk("R1 cas_inh in reset", cas_inh, 1'b0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 rfreq_n after reset", rfreq_n, 1'b1);

    // R2: hidden refresh in idle auto-access mode
    mode = M_AUTO;
    expect_go(M_AUTO);
    acc_busy = 1'b0;
    cyc(1);
    chk("R2 go pulse", rfsh_go, 1'b1);
    chk("R11 cas_inh during hidden refresh", cas_inh, 1'b1);
    cyc(1);
    chk("R2 go one cycle", rfsh_go, 1'b0);
    cyc(RF_CYC);
    chk("R11 cas_inh low after refresh", cas_inh, 1'b0);
    // R3: long idle, no second hidden refresh
    cyc(30);
    drained("R3 one hidden per period");

    // R4: period ends with hidden refresh done
    expect_go(M_AUTO);
    rfck = 1'b1;
    cyc(8);
    chk("R4 no request after hidden", rfreq_n, 1'b1);
    drained("R4 new period hidden refresh");

    // R5: full period busy, no hidden refresh
    acc_busy = 1'b1;
    rfck = 1'b0; cyc(6); rfck = 1'b1; cyc(6);
    chk("R5 first edge no request", rfreq_n, 1'b1);
    rfck = 1'b0; cyc(6); rfck = 1'b1; cyc(6);
    chk("R5 request raised", rfreq_n, 1'b0);

    // R6: idle auto-access while request pending
    acc_busy = 1'b0;
    cyc(20);
    chk("R6 request held", rfreq_n, 1'b0);
    drained("R6 no hidden while pending");

    // R7 / R8: acknowledge through forced mode
    expect_go(M_FRC);
    mode = M_FRC;
    cyc(1);
    chk("R7 forced go", rfsh_go, 1'b1);
    chk("R11 cas_inh forced", cas_inh, 1'b1);
    cyc(RF_CYC - 1);
    chk("R8 request still low in last cycle", rfreq_n, 1'b0);
    cyc(1);
    chk("R8 request released", rfreq_n, 1'b1);
    // R9: held acknowledge, no second refresh
    cyc(30);
    chk("R11 cas_inh held in forced mode", cas_inh, 1'b1);
    drained("R9 one forced refresh");

    // R10 / R12: rfck held high, re-enter forced mode
    for (int k = 0; k < 2; k++) begin
      mode = M_EXT;
      cyc(6);
      chk("R11 cas_inh low in other mode", cas_inh, 1'b0);
      drained("R12 no refresh in other mode");
      expect_go(M_FRC);
      mode = M_FRC;
      cyc(15);
      drained("R10 one refresh per entry");
      chk("R10 no request", rfreq_n, 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule